// File: doc/BRIEF.md
# Dual-Role Slot-31 Integer Register File

This block holds the integer state of a 64-bit execution core. It has 32 index positions. Indices 0 to 30 are ordinary registers. Index 31 has two meanings, and the meaning is chosen separately on every access by a per-port flag. With the flag set, index 31 is a real stored stack pointer. With the flag clear, index 31 is a zero register: it reads as zero and any write to it is thrown away.

There are two combinational read ports and one write port, and the write port updates state on the rising clock edge.

Each read port picks its result width from a size code: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 is 32 bits and 2'b11 is 64 bits. The bits are always taken from the low end of the register. A separate sign flag chooses sign extension or zero extension of the narrow value to 64 bits.

A write is either full width or half width. A half-width write stores the low 32 bits of the data and clears the upper 32 bits of the target register. There is no write-to-read forwarding, so the pipeline around the block must handle a read-after-write in the same cycle.

Top module: `gpr_dual31_file`

## Requirements
- R1: A read at index 31 with its stack-pointer flag clear returns 64'h0, whatever the stored stack pointer holds.
- R2: A write at index 31 with its stack-pointer flag clear changes no register, and in particular leaves the stored stack pointer unchanged.
- R3: With the stack-pointer flag set, index 31 is a stored register: a write there is read back at index 31 with the flag set.
- R4: A full-width write (`wr_full`=1) replaces all 64 bits of the target register.
- R5: A half-width write (`wr_full`=0) stores data bits 31:0 and sets bits 63:32 of the target register to zero.
- R6: An unsigned read (sign flag 0) of size code 00, 01 or 10 returns the low 8, 16 or 32 register bits with zeros above them; size code 11 returns all 64 bits.
- R7: A signed read (sign flag 1) of size code 00, 01 or 10 copies bit 7, 15 or 31 into every higher result bit.
- R8: A read in the same cycle as a write to the same index returns the value held before the write; the new value is visible from the cycle after the clock edge.
- R9: The two read ports resolve index 31 independently, each by its own flag, in the same cycle.
- R10: A synchronous active-high reset sets all 31 ordinary registers and the stack pointer to zero.
- R11: A write to one ordinary index leaves every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_sp | input | 1 | Index 31 of the write means stack pointer (1) or zero register (0) |
| wr_full | input | 1 | 1: 64-bit write, 0: 32-bit write with upper half cleared |
| wr_data | input | 64 | Write data |
| ra_idx | input | 5 | Read port A index |
| ra_sp | input | 1 | Read port A: index 31 means stack pointer (1) or zero (0) |
| ra_size | input | 2 | Read port A size code (00=8, 01=16, 10=32, 11=64 bits) |
| ra_sext | input | 1 | Read port A: 1 sign-extends, 0 zero-extends |
| ra_data | output | 64 | Read port A result |
| rb_idx | input | 5 | Read port B index |
| rb_sp | input | 1 | Read port B: index 31 means stack pointer (1) or zero (0) |
| rb_size | input | 2 | Read port B size code (00=8, 01=16, 10=32, 11=64 bits) |
| rb_sext | input | 1 | Read port B: 1 sign-extends, 0 zero-extends |
| rb_data | output | 64 | Read port B result |

## Verification
The hardest case to reach is a discarded write to the zero register when the stored stack pointer already holds a non-zero value. This case is the only one that separates "the write was dropped" from "the write went to the stack pointer".

The stimulus first loads the stack pointer with a distinctive pattern in stack-pointer mode. It then writes a different pattern to index 31 in zero-register mode. Finally it reads index 31 on both ports in the same cycle, one port in each mode.

The stored pattern must survive on the port with the flag set, and the other port must show zero. The no-forwarding rule is exercised by holding a read on the written index across the write edge, with a check before the edge and a check after it.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int XLEN = 64;
    localparam int HLEN = XLEN / 2;

    // Read width selector; encoding is part of the port contract.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_FULL = 2'b11
    } rsize_e;

    // Narrow and extend a raw register value to XLEN bits.
    function automatic logic [XLEN-1:0] fit_value(
        input logic [XLEN-1:0] v,
        input rsize_e          sz,
        input logic            sx
    );
        logic [XLEN-1:0] r;
        case (sz)
            SZ_BYTE: r = sx ? {{(XLEN-8){v[7]}},   v[7:0]}
                            : {{(XLEN-8){1'b0}},   v[7:0]};
            SZ_HALF: r = sx ? {{(XLEN-16){v[15]}}, v[15:0]}
                            : {{(XLEN-16){1'b0}},  v[15:0]};
            SZ_WORD: r = sx ? {{(XLEN-32){v[31]}}, v[31:0]}
                            : {{(XLEN-32){1'b0}},  v[31:0]};
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpr_store.sv
module gpr_store
    import gpr_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_idx,
    input  logic                       wr_sp,
    input  logic                       wr_full,
    input  logic [XLEN-1:0]            wr_data,
    output logic [NREG-1:0][XLEN-1:0]  regs
);

    localparam logic [AW-1:0] SP_IDX = AW'(NREG - 1);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
    } store_t;

    store_t st_d, st_q;
    logic   wr_sink;

    assign wr_sink = (wr_idx == SP_IDX) && !wr_sp;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_sink) begin
            if (wr_full)
                st_d.regs[wr_idx] = wr_data;
            else
                st_d.regs[wr_idx] = {{HLEN{1'b0}}, wr_data[HLEN-1:0]};
        end
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs = st_q.regs;

    AST_SINK_KEEPS_SP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == SP_IDX && !wr_sp) |=>
            (st_q.regs[SP_IDX] == $past(st_q.regs[SP_IDX]))); // R2

    AST_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_full && !wr_sink) |=>
            (st_q.regs[$past(wr_idx)] == $past(wr_data))); // R4

    AST_HALF_WRITE_UPPER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_full && !wr_sink) |=>
            (st_q.regs[$past(wr_idx)][XLEN-1:HLEN] == '0)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (st_q.regs == '0)); // R10

endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
    import gpr_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic [NREG-1:0][XLEN-1:0] regs,
    input  logic [AW-1:0]             idx,
    input  logic                      sp_sel,
    input  logic [1:0]                size,
    input  logic                      sext,
    output logic [XLEN-1:0]           data
);

    localparam logic [AW-1:0] SP_IDX = AW'(NREG - 1);

    logic [XLEN-1:0] raw;

    always_comb begin
        if (idx == SP_IDX && !sp_sel)
            raw = '0;
        else
            raw = regs[idx];
        data = fit_value(raw, rsize_e'(size), sext);
    end

endmodule

// File: rtl/gpr_dual31_file.sv
module gpr_dual31_file
    import gpr_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int NRD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic            wr_sp,
    input  logic            wr_full,
    input  logic [XLEN-1:0] wr_data,
    input  logic [AW-1:0]   ra_idx,
    input  logic            ra_sp,
    input  logic [1:0]      ra_size,
    input  logic            ra_sext,
    output logic [XLEN-1:0] ra_data,
    input  logic [AW-1:0]   rb_idx,
    input  logic            rb_sp,
    input  logic [1:0]      rb_size,
    input  logic            rb_sext,
    output logic [XLEN-1:0] rb_data
);

    localparam logic [AW-1:0] SP_IDX = AW'(NREG - 1);

    logic [NREG-1:0][XLEN-1:0] regs;
    logic [AW-1:0]             p_idx  [NRD];
    logic                      p_sp   [NRD];
    logic [1:0]                p_size [NRD];
    logic                      p_sext [NRD];
    logic [XLEN-1:0]           p_data [NRD];

    gpr_store #(.NREG(NREG)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_sp   (wr_sp),
        .wr_full (wr_full),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign p_idx[0]  = ra_idx;   assign p_idx[1]  = rb_idx;
    assign p_sp[0]   = ra_sp;    assign p_sp[1]   = rb_sp;
    assign p_size[0] = ra_size;  assign p_size[1] = rb_size;
    assign p_sext[0] = ra_sext;  assign p_sext[1] = rb_sext;
    assign ra_data   = p_data[0];
    assign rb_data   = p_data[1];

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        gpr_rd_port #(.NREG(NREG)) u_port (
            .regs   (regs),
            .idx    (p_idx[g]),
            .sp_sel (p_sp[g]),
            .size   (p_size[g]),
            .sext   (p_sext[g]),
            .data   (p_data[g])
        );

        AST_ZERO_SLOT_READ: assert property (@(posedge clk) disable iff (rst)
            (p_idx[g] == SP_IDX && !p_sp[g]) |-> (p_data[g] == '0)); // R1

        AST_BYTE_SIGNED: assert property (@(posedge clk) disable iff (rst)
            (p_size[g] == 2'b00 && p_sext[g]) |->
                (p_data[g][XLEN-1:8] == {(XLEN-8){p_data[g][7]}})); // R7

        AST_NARROW_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
            (p_size[g] == 2'b01 && !p_sext[g]) |->
                (p_data[g][XLEN-1:16] == '0)); // R6
    end

endmodule

// File: tb/sim_gpr_dual31_file.sv
module sim_gpr_dual31_file;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_sp, wr_full;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;
    logic [4:0]  ra_idx, rb_idx;
    logic        ra_sp, rb_sp, ra_sext, rb_sext;
    logic [1:0]  ra_size, rb_size;
    logic [63:0] ra_data, rb_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    gpr_dual31_file u0 (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sp(wr_sp), .wr_full(wr_full), .wr_data(wr_data),
        .ra_idx(ra_idx), .ra_sp(ra_sp), .ra_size(ra_size), .ra_sext(ra_sext), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_sp(rb_sp), .rb_size(rb_size), .rb_sext(rb_sext), .rb_data(rb_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write(input logic [4:0] idx, input logic sp, input logic full,
                         input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_sp = sp; wr_full = full; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_a(input logic [4:0] idx, input logic sp, input logic [1:0] sz,
                          input logic sx, output logic [63:0] v);
        ra_idx = idx; ra_sp = sp; ra_size = sz; ra_sext = sx;
        #1 v = ra_data;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        write(5'd3, 1'b1, 1'b1, 64'hAAAA_5555_1234_9876);
        write(5'd31, 1'b1, 1'b1, 64'h7777_0000_0000_1000);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 32; i++) begin
            read_a(5'(i), 1'b1, 2'b11, 1'b0, v);
            check("R10 reset clears", v, 64'h0);
        end
    endtask

    task automatic t_width_writes();
        logic [63:0] v;
        write(5'd5, 1'b0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D);
        read_a(5'd5, 1'b0, 2'b11, 1'b0, v);
        check("R4 full write", v, 64'hDEAD_BEEF_CAFE_F00D);
        write(5'd5, 1'b0, 1'b0, 64'h1111_2222_8765_4321);
        read_a(5'd5, 1'b0, 2'b11, 1'b0, v);
        check("R5 half write clears upper", v, 64'h0000_0000_8765_4321);
    endtask

    task automatic t_slot31();
        write(5'd31, 1'b1, 1'b1, 64'h0000_7FFF_FFF0_1230);
        read_a(5'd31, 1'b1, 2'b11, 1'b0, ra_data);
        check("R3 stack pointer stored", ra_data, 64'h0000_7FFF_FFF0_1230);
        write(5'd31, 1'b0, 1'b1, 64'h5A5A_5A5A_5A5A_5A5A);
        ra_idx = 5'd31; ra_sp = 1'b1; ra_size = 2'b11; ra_sext = 1'b0;
        rb_idx = 5'd31; rb_sp = 1'b0; rb_size = 2'b11; rb_sext = 1'b1;
        #1;
        check("R2 sink write keeps SP", ra_data, 64'h0000_7FFF_FFF0_1230);
        check("R1 zero slot reads zero", rb_data, 64'h0);
        check("R9 ports independent A", ra_data, 64'h0000_7FFF_FFF0_1230);
        ra_sp = 1'b0; rb_sp = 1'b1;
        #1;
        check("R9 ports independent swapped A", ra_data, 64'h0);
        check("R9 ports independent swapped B", rb_data, 64'h0000_7FFF_FFF0_1230);
    endtask

    task automatic t_narrow();
        logic [63:0] v;
        write(5'd9, 1'b0, 1'b1, 64'h0123_4567_89AB_80EF);
        read_a(5'd9, 1'b0, 2'b00, 1'b0, v); check("R6 byte unsigned", v, 64'h0000_0000_0000_00EF);
        read_a(5'd9, 1'b0, 2'b01, 1'b0, v); check("R6 half unsigned", v, 64'h0000_0000_0000_80EF);
        read_a(5'd9, 1'b0, 2'b10, 1'b0, v); check("R6 word unsigned", v, 64'h0000_0000_89AB_80EF);
        read_a(5'd9, 1'b0, 2'b11, 1'b1, v); check("R6 full read", v, 64'h0123_4567_89AB_80EF);
        read_a(5'd9, 1'b0, 2'b00, 1'b1, v); check("R7 byte signed", v, 64'hFFFF_FFFF_FFFF_FFEF);
        read_a(5'd9, 1'b0, 2'b01, 1'b1, v); check("R7 half signed", v, 64'hFFFF_FFFF_FFFF_80EF);
        read_a(5'd9, 1'b0, 2'b10, 1'b1, v); check("R7 word signed", v, 64'hFFFF_FFFF_89AB_80EF);
        write(5'd10, 1'b0, 1'b1, 64'hFEDC_BA98_7654_3210);
        read_a(5'd10, 1'b0, 2'b00, 1'b1, v); check("R7 byte signed positive", v, 64'h10);
        read_a(5'd10, 1'b0, 2'b10, 1'b1, v); check("R7 word signed positive", v, 64'h7654_3210);
    endtask

    task automatic t_no_bypass();
        write(5'd7, 1'b0, 1'b1, 64'h0000_0000_0000_0111);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd7; wr_sp = 1'b0; wr_full = 1'b1; wr_data = 64'h0000_0000_0000_0222;
        ra_idx = 5'd7; ra_sp = 1'b0; ra_size = 2'b11; ra_sext = 1'b0;
        #1 check("R8 same-cycle read old", ra_data, 64'h111);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R8 new value after edge", ra_data, 64'h222);
    endtask

    task automatic t_isolation();
        logic [63:0] v;
        write(5'd1, 1'b0, 1'b1, 64'h1);
        write(5'd29, 1'b0, 1'b1, 64'h29);
        write(5'd0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        write(5'd30, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        read_a(5'd1, 1'b0, 2'b11, 1'b0, v);  check("R11 neighbour 1 kept", v, 64'h1);
        read_a(5'd29, 1'b0, 2'b11, 1'b0, v); check("R11 neighbour 29 kept", v, 64'h29);
        read_a(5'd0, 1'b0, 2'b11, 1'b0, v);  check("R11 index 0 written", v, 64'hFFFF_FFFF_FFFF_FFFF);
        read_a(5'd30, 1'b0, 2'b11, 1'b0, v); check("R11 index 30 written", v, 64'h0000_0000_FFFF_FFFF);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_sp = 1'b0; wr_full = 1'b0; wr_data = '0;
        ra_idx = '0; ra_sp = 1'b0; ra_size = 2'b11; ra_sext = 1'b0;
        rb_idx = '0; rb_sp = 1'b0; rb_size = 2'b11; rb_sext = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_width_writes();
        t_slot31();
        t_narrow();
        t_no_bypass();
        t_isolation();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule